// File: doc/BRIEF.md
# ADC Sequencer Low-Power Wait Controller

This block is the flow-control core of an ADC conversion sequencer, and it handles the chip's low-power wait state. It keeps four sticky flow-control request bits: trigger, restart, sequence abort and buffer swap (load-ok). It starts conversions on a built-in fixed-latency converter model. It advances the command index and the result-list index, and it picks one of two result buffers.

The stop-in-wait configuration bit sets how a wait request is handled. When the bit is clear, wait is transparent to the sequencer. When the bit is set, a wait request that arrives while work is in progress forces a sequence abort, and the conversion in flight is allowed to finish. All flow-control bits are held at zero for as long as wait lasts.

On leaving wait, a restart can be raised automatically. In trigger flow mode this restart also requests a trigger. In restart flow mode it raises the restart alone. Software may also run the abort itself before it requests wait, and it can poll a sticky abort-done flag for that purpose.

Top module: `adc_wait_ctrl`

## Requirements
- R1: With `cfg_stop_in_wait`=0, a high `lp_wait` changes nothing. Strobes are serviced and conversions start and complete as they do outside wait.
- R2: With `cfg_stop_in_wait`=1, a rising `lp_wait` while a conversion runs or `cmd_idx`≠0 starts an internal abort. The running conversion keeps `conv_busy` high until its full latency of `CONV_LAT` cycles has elapsed.
- R3: The conversion that ends an abort pulses `result_wr` only when `cfg_store_on_abort`=1. When that bit is 0, no `result_wr` pulse is produced.
- R4: Abort completion clears `cmd_idx` and `rvl_idx` and sets the sticky `abort_done`. `abort_done` stays set until an `abort_done_clr` pulse, and a completion in the same cycle as the clear pulse wins.
- R5: While `cfg_stop_in_wait`=1 and `lp_wait`=1, the four flow bits read 0 from the next cycle on. Software strobes raised in that time are ignored.
- R6: In trigger mode (`cfg_trig_mode`=1) with `cfg_auto_restart`=1, the cycle after `lp_wait` falls shows both `flow_rsta` and `flow_trig` set. The restart then clears the indices, and a conversion starts in the cycle after that.
- R7: In restart mode (`cfg_trig_mode`=0) with `cfg_auto_restart`=1, the exit sets `flow_rsta` only. `flow_seqa` and `flow_trig` stay 0, and no conversion starts.
- R8: With `cfg_auto_restart`=0, leaving wait sets no flow bit.
- R9: `buf_sel` toggles only when a non-aborted conversion of the last command (`cmd_idx`=`SEQ_LEN`-1) completes while `flow_ldok` is set. Once the first cycle of a stop-in-wait period has passed, it does not change.
- R10: A trigger starts a conversion when no conversion, restart or abort is pending. `result_wr` pulses in the last of `CONV_LAT` busy cycles, and both indices then advance, wrapping to 0 after `SEQ_LEN`-1.
- R11: `idle` is 1 exactly when no conversion runs, `cmd_idx` is 0, and no abort (software or automatic) is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lp_wait | input | 1 | Low-power wait request level; its fall is the wait exit |
| cfg_stop_in_wait | input | 1 | 1: stop and abort on wait |
| cfg_store_on_abort | input | 1 | 1: store the result of the conversion that ends an abort |
| cfg_auto_restart | input | 1 | 1: raise the restart automatically on wait exit |
| cfg_trig_mode | input | 1 | 1: trigger flow mode, 0: restart flow mode |
| sw_trig | input | 1 | Software trigger strobe |
| sw_restart | input | 1 | Software restart strobe |
| sw_abort | input | 1 | Software sequence abort strobe |
| sw_ldok | input | 1 | Software buffer-swap (load-ok) strobe |
| abort_done_clr | input | 1 | Write-one-to-clear pulse for `abort_done` |
| conv_busy | output | 1 | Converter model is converting |
| result_wr | output | 1 | Result stored this cycle |
| cmd_idx | output | $clog2(SEQ_LEN) | Command index |
| rvl_idx | output | $clog2(SEQ_LEN) | Result-list index |
| buf_sel | output | 1 | Selected result buffer |
| flow_trig | output | 1 | Pending trigger bit |
| flow_rsta | output | 1 | Pending restart bit |
| flow_seqa | output | 1 | Pending software abort bit |
| flow_ldok | output | 1 | Pending buffer-swap bit |
| abort_done | output | 1 | Sticky abort-complete flag |
| idle | output | 1 | No conversion, list position or abort outstanding |

## Verification
The hardest case to reach is a wait request that lands in the very cycle a conversion completes. In that cycle the completion counts as a normal one, and the abort has to run on the following cycle against an idle converter. The stimulus reaches this case by counting negedges from a trigger strobe so that the `lp_wait` edge coincides with the final busy cycle. Wait requests also arrive mid-conversion, after a software abort, with a buffer swap pending mid-list, and under each pairing of flow mode and auto-restart. A behavioural model tracks every output on every cycle.

// File: rtl/adc_wait_pkg.sv
`timescale 1ns/1ps
package adc_wait_pkg;
  localparam int FLOW_N  = 4;
  localparam int FB_TRIG = 0;
  localparam int FB_RSTA = 1;
  localparam int FB_SEQA = 2;
  localparam int FB_LDOK = 3;
endpackage

// File: rtl/adc_conv_model.sv
`timescale 1ns/1ps
// Fixed-latency converter stand-in: busy for LAT cycles, done in the last one.
module adc_conv_model #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (LAT > 2) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign done_o = busy_q && (cnt_q == LAST);
  assign busy_o = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (done_o) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/adc_flow_bits.sv
`timescale 1ns/1ps
// Sticky request bits: set by strobe, cleared when serviced, forced low by hold.
module adc_flow_bits #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] srv_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q, d;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_comb begin
      if (hold_i) d[g] = 1'b0;
      else        d[g] = (q[g] & ~srv_i[g]) | set_i[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[g] <= 1'b0;
      else        q[g] <= d[g];
    end
  end

  assign q_o = q;
endmodule

// File: rtl/adc_idx_ctrl.sv
`timescale 1ns/1ps
// Command index, result-list index and result buffer select.
module adc_idx_ctrl #(
  parameter int SEQ_LEN = 4,
  localparam int IW = $clog2(SEQ_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          adv_i,
  input  logic          ldok_i,
  output logic          list_end_o,
  output logic [IW-1:0] cmd_o,
  output logic [IW-1:0] rvl_o,
  output logic          buf_o
);
  localparam logic [IW-1:0] LAST = IW'(SEQ_LEN - 1);

  logic [IW-1:0] cmd_q, cmd_d, rvl_q, rvl_d;
  logic          buf_q, buf_d;

  assign list_end_o = adv_i && (cmd_q == LAST);

  always_comb begin
    cmd_d = cmd_q;
    rvl_d = rvl_q;
    buf_d = buf_q;
    if (clear_i) begin
      cmd_d = '0;
      rvl_d = '0;
    end else if (adv_i) begin
      if (list_end_o) begin
        cmd_d = '0;
        rvl_d = '0;
        if (ldok_i) buf_d = ~buf_q;
      end else begin
        cmd_d = cmd_q + 1'b1;
        rvl_d = rvl_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      rvl_q <= '0;
      buf_q <= 1'b0;
    end else begin
      cmd_q <= cmd_d;
      rvl_q <= rvl_d;
      buf_q <= buf_d;
    end
  end

  assign cmd_o = cmd_q;
  assign rvl_o = rvl_q;
  assign buf_o = buf_q;
endmodule

// File: rtl/adc_wait_ctrl.sv
`timescale 1ns/1ps
module adc_wait_ctrl
  import adc_wait_pkg::*;
#(
  parameter int SEQ_LEN  = 4,
  parameter int CONV_LAT = 3,
  localparam int IW = $clog2(SEQ_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lp_wait,
  input  logic          cfg_stop_in_wait,
  input  logic          cfg_store_on_abort,
  input  logic          cfg_auto_restart,
  input  logic          cfg_trig_mode,
  input  logic          sw_trig,
  input  logic          sw_restart,
  input  logic          sw_abort,
  input  logic          sw_ldok,
  input  logic          abort_done_clr,
  output logic          conv_busy,
  output logic          result_wr,
  output logic [IW-1:0] cmd_idx,
  output logic [IW-1:0] rvl_idx,
  output logic          buf_sel,
  output logic          flow_trig,
  output logic          flow_rsta,
  output logic          flow_seqa,
  output logic          flow_ldok,
  output logic          abort_done,
  output logic          idle
);
  logic              wait_q, auto_ab_q, auto_ab_d, abort_done_q, abort_done_d;
  logic              hold, wait_rise, exit_auto, ab_pend, seq_active;
  logic              abort_go, rst_go, conv_start, conv_done, adv, list_end;
  logic [FLOW_N-1:0] flow_q, flow_set, flow_srv;

  assign hold       = cfg_stop_in_wait & lp_wait;
  assign wait_rise  = lp_wait & ~wait_q;
  assign exit_auto  = ~lp_wait & wait_q & cfg_stop_in_wait & cfg_auto_restart;
  assign ab_pend    = flow_q[FB_SEQA] | auto_ab_q;
  assign seq_active = conv_busy | (cmd_idx != '0);
  assign abort_go   = ab_pend & (~conv_busy | conv_done);
  assign rst_go     = flow_q[FB_RSTA] & ~conv_busy & ~ab_pend & ~hold;
  assign conv_start = flow_q[FB_TRIG] & ~flow_q[FB_RSTA] & ~conv_busy & ~ab_pend & ~hold;
  assign adv        = conv_done & ~ab_pend;
  assign result_wr  = conv_done & (~ab_pend | cfg_store_on_abort);

  always_comb begin
    flow_set          = '0;
    flow_set[FB_TRIG] = sw_trig | (exit_auto & cfg_trig_mode);
    flow_set[FB_RSTA] = sw_restart | exit_auto;
    flow_set[FB_SEQA] = sw_abort;
    flow_set[FB_LDOK] = sw_ldok;
    flow_srv          = '0;
    flow_srv[FB_TRIG] = conv_start;
    flow_srv[FB_RSTA] = rst_go;
    flow_srv[FB_SEQA] = abort_go;
    flow_srv[FB_LDOK] = list_end;
  end

  always_comb begin
    auto_ab_d    = auto_ab_q | (wait_rise & cfg_stop_in_wait & (seq_active | flow_q[FB_SEQA]));
    if (abort_go) auto_ab_d = 1'b0;
    abort_done_d = abort_go | (abort_done_q & ~abort_done_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q       <= 1'b0;
      auto_ab_q    <= 1'b0;
      abort_done_q <= 1'b0;
    end else begin
      wait_q       <= lp_wait;
      auto_ab_q    <= auto_ab_d;
      abort_done_q <= abort_done_d;
    end
  end

  adc_flow_bits #(.N(FLOW_N)) flow_i (
    .clk(clk), .rst_n(rst_n), .hold_i(hold),
    .set_i(flow_set), .srv_i(flow_srv), .q_o(flow_q)
  );

  adc_conv_model #(.LAT(CONV_LAT)) conv_i (
    .clk(clk), .rst_n(rst_n), .start_i(conv_start),
    .busy_o(conv_busy), .done_o(conv_done)
  );

  adc_idx_ctrl #(.SEQ_LEN(SEQ_LEN)) idx_i (
    .clk(clk), .rst_n(rst_n), .clear_i(abort_go | rst_go), .adv_i(adv),
    .ldok_i(flow_q[FB_LDOK]), .list_end_o(list_end),
    .cmd_o(cmd_idx), .rvl_o(rvl_idx), .buf_o(buf_sel)
  );

  assign flow_trig  = flow_q[FB_TRIG];
  assign flow_rsta  = flow_q[FB_RSTA];
  assign flow_seqa  = flow_q[FB_SEQA];
  assign flow_ldok  = flow_q[FB_LDOK];
  assign abort_done = abort_done_q;
  assign idle       = ~seq_active & ~ab_pend;
endmodule

// File: rtl/adc_wait_ctrl_chk.sv
`timescale 1ns/1ps
module adc_wait_ctrl_chk #(
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lp_wait,
  input logic          wait_q,
  input logic          cfg_stop_in_wait,
  input logic          cfg_auto_restart,
  input logic          cfg_trig_mode,
  input logic          sw_trig,
  input logic          sw_abort,
  input logic          conv_busy,
  input logic          conv_done,
  input logic          ab_pend,
  input logic [IW-1:0] cmd_idx,
  input logic [IW-1:0] rvl_idx,
  input logic          buf_sel,
  input logic          flow_trig,
  input logic          flow_rsta,
  input logic          flow_seqa,
  input logic          flow_ldok,
  input logic          abort_done
);
  p_busy_until_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_busy && !conv_done) |=> conv_busy);

  p_flow_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stop_in_wait && lp_wait) |=> !(flow_trig || flow_rsta || flow_seqa || flow_ldok));

  p_abort_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_pend && (!conv_busy || conv_done)) |=> (abort_done && cmd_idx == '0 && rvl_idx == '0));

  p_exit_trig_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && !lp_wait && cfg_stop_in_wait && cfg_auto_restart && cfg_trig_mode)
      |=> (flow_rsta && flow_trig));

  p_exit_restart_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && !lp_wait && cfg_stop_in_wait && cfg_auto_restart && !cfg_trig_mode &&
     !sw_trig && !sw_abort && !flow_trig && !flow_seqa)
      |=> (flow_rsta && !flow_seqa && !flow_trig));

  p_buf_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stop_in_wait && lp_wait && wait_q && !flow_ldok) |=> $stable(buf_sel));
endmodule

bind adc_wait_ctrl adc_wait_ctrl_chk #(.IW(IW)) chk_i (
  .clk(clk), .rst_n(rst_n), .lp_wait(lp_wait), .wait_q(wait_q),
  .cfg_stop_in_wait(cfg_stop_in_wait), .cfg_auto_restart(cfg_auto_restart),
  .cfg_trig_mode(cfg_trig_mode), .sw_trig(sw_trig), .sw_abort(sw_abort),
  .conv_busy(conv_busy), .conv_done(conv_done), .ab_pend(ab_pend),
  .cmd_idx(cmd_idx), .rvl_idx(rvl_idx), .buf_sel(buf_sel),
  .flow_trig(flow_trig), .flow_rsta(flow_rsta), .flow_seqa(flow_seqa),
  .flow_ldok(flow_ldok), .abort_done(abort_done)
);

// File: tb/adc_wait_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_wait_ctrl_tb_top;
  localparam int SEQ = 4;
  localparam int LAT = 3;
  localparam int IW  = $clog2(SEQ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lp_wait = 0, stop = 0, store = 0, autor = 0, tmode = 0;
  logic s_trig = 0, s_rsta = 0, s_abort = 0, s_ldok = 0, ad_clr = 0;
  logic conv_busy, result_wr, buf_sel, f_trig, f_rsta, f_seqa, f_ldok, abort_done, idle;
  logic [IW-1:0] cmd_idx, rvl_idx;

  int checks = 0, errors = 0, n_wr = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adc_wait_ctrl #(.SEQ_LEN(SEQ), .CONV_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .lp_wait(lp_wait), .cfg_stop_in_wait(stop),
    .cfg_store_on_abort(store), .cfg_auto_restart(autor), .cfg_trig_mode(tmode),
    .sw_trig(s_trig), .sw_restart(s_rsta), .sw_abort(s_abort), .sw_ldok(s_ldok),
    .abort_done_clr(ad_clr), .conv_busy(conv_busy), .result_wr(result_wr),
    .cmd_idx(cmd_idx), .rvl_idx(rvl_idx), .buf_sel(buf_sel),
    .flow_trig(f_trig), .flow_rsta(f_rsta), .flow_seqa(f_seqa), .flow_ldok(f_ldok),
    .abort_done(abort_done), .idle(idle)
  );

  // Behavioural reference model
  bit m_busy, m_trig, m_rsta, m_seqa, m_ldok, m_auto, m_ad, m_buf, m_wq;
  int m_cnt, m_cmd, m_rvl;

  function automatic bit mx_abp();  return m_seqa || m_auto; endfunction
  function automatic bit mx_done(); return m_busy && (m_cnt == LAT - 1); endfunction
  function automatic bit mx_wr();   return mx_done() && (!mx_abp() || store); endfunction
  function automatic bit mx_idle(); return !m_busy && m_cmd == 0 && !mx_abp(); endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_busy, m_trig, m_rsta, m_seqa, m_ldok, m_auto, m_ad, m_buf, m_wq} = '0;
      m_cnt = 0; m_cmd = 0; m_rvl = 0;
    end else begin
      bit hold, abp, done, stopping, restarting, starting, was_active, exiting;
      hold       = stop && lp_wait;
      abp        = mx_abp();
      done       = mx_done();
      was_active = m_busy || m_cmd != 0;
      stopping   = abp && (!m_busy || done);
      restarting = m_rsta && !m_busy && !abp && !hold;
      starting   = m_trig && !m_rsta && !m_busy && !abp && !hold;
      exiting    = m_wq && !lp_wait && stop && autor;
      // indices and buffer
      if (stopping || restarting) begin
        m_cmd = 0; m_rvl = 0;
      end else if (done) begin
        if (m_cmd == SEQ - 1) begin
          m_cmd = 0; m_rvl = 0;
          if (m_ldok) m_buf = !m_buf;
          m_ldok = 0;
        end else begin
          m_cmd++; m_rvl++;
        end
      end
      // auto abort and sticky flag
      if (stopping) m_auto = 0;
      else if (lp_wait && !m_wq && stop && (was_active || m_seqa)) m_auto = 1;
      if (stopping) m_ad = 1;
      else if (ad_clr) m_ad = 0;
      // converter
      if (starting) begin m_busy = 1; m_cnt = 0; end
      else if (done) begin m_busy = 0; m_cnt = 0; end
      else if (m_busy) m_cnt++;
      // flow bits
      if (hold) begin
        {m_trig, m_rsta, m_seqa, m_ldok} = '0;
      end else begin
        if (starting) m_trig = 0;
        if (restarting) m_rsta = 0;
        if (stopping) m_seqa = 0;
        if (s_trig || (exiting && tmode)) m_trig = 1;
        if (s_rsta || exiting) m_rsta = 1;
        if (s_abort) m_seqa = 1;
        if (s_ldok) m_ldok = 1;
      end
      m_wq = lp_wait;
    end
  end

  task automatic chk(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(conv_busy,  m_busy,    "R2",  "conv_busy");
    chk(result_wr,  mx_wr(),   "R3",  "result_wr");
    chk(cmd_idx,    m_cmd,     "R10", "cmd_idx");
    chk(rvl_idx,    m_rvl,     "R10", "rvl_idx");
    chk(buf_sel,    m_buf,     "R9",  "buf_sel");
    chk(f_trig,     m_trig,    "R5",  "flow_trig");
    chk(f_rsta,     m_rsta,    "R5",  "flow_rsta");
    chk(f_seqa,     m_seqa,    "R5",  "flow_seqa");
    chk(f_ldok,     m_ldok,    "R5",  "flow_ldok");
    chk(abort_done, m_ad,      "R4",  "abort_done");
    chk(idle,       mx_idle(), "R11", "idle");
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (result_wr) n_wr++;
      compare_all();
    end
  endtask

  task automatic p_trig();  s_trig = 1;  ticks(1); s_trig = 0;  endtask
  task automatic p_rsta();  s_rsta = 1;  ticks(1); s_rsta = 0;  endtask
  task automatic p_abort(); s_abort = 1; ticks(1); s_abort = 0; endtask
  task automatic p_ldok();  s_ldok = 1;  ticks(1); s_ldok = 0;  endtask
  task automatic p_clr();   ad_clr = 1;  ticks(1); ad_clr = 0;  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int w0;
    bit b0;
    ticks(3);
    chk(idle, 1, "R11", "idle in reset");
    chk(abort_done, 0, "R4", "abort_done in reset");
    rst_n = 1;
    ticks(2);

    // R10 / R9: a full list with a buffer swap request
    p_ldok();
    w0 = n_wr;
    for (int k = 0; k < SEQ; k++) begin p_trig(); ticks(5); end
    chk(n_wr - w0, SEQ, "R10", "results over one list");
    chk(cmd_idx, 0, "R10", "cmd_idx wraps");
    chk(buf_sel, 1, "R9", "buffer swapped at list end");

    // R1: wait without stop is transparent
    lp_wait = 1;
    w0 = n_wr;
    p_trig(); ticks(6);
    chk(n_wr - w0, 1, "R1", "conversion during transparent wait");
    chk(cmd_idx, 1, "R1", "index advanced during wait");
    lp_wait = 0; ticks(1);
    p_rsta(); ticks(2);
    chk(cmd_idx, 0, "R1", "restart serviced");

    // R2 R3 R4 R5 R6: auto abort with store, trigger-mode auto restart
    stop = 1; store = 1; autor = 1; tmode = 1;
    p_trig(); ticks(1);
    lp_wait = 1; w0 = n_wr; ticks(1);
    chk(conv_busy, 1, "R2", "conversion continues after wait");
    p_trig();
    chk(f_trig, 0, "R5", "trigger ignored in wait");
    ticks(4);
    chk(n_wr - w0, 1, "R3", "result stored on abort");
    chk(abort_done, 1, "R4", "abort_done set");
    chk(idle, 1, "R11", "idle after abort");
    p_clr();
    chk(abort_done, 0, "R4", "abort_done cleared");
    lp_wait = 0; ticks(1);
    chk(f_rsta & f_trig, 1, "R6", "exit sets restart and trigger");
    ticks(2);
    chk(conv_busy, 1, "R6", "conversion after restart");
    ticks(4);

    // R3 R7: discard on abort, restart-mode auto restart
    store = 0; tmode = 0;
    p_trig(); ticks(1);
    lp_wait = 1; w0 = n_wr; ticks(5);
    chk(n_wr - w0, 0, "R3", "no result stored on abort");
    lp_wait = 0; ticks(1);
    chk(f_rsta, 1, "R7", "restart bit set");
    chk(f_seqa | f_trig, 0, "R7", "abort and trigger clear");
    ticks(3);
    chk(conv_busy, 0, "R7", "no conversion after restart");
    chk(cmd_idx, 0, "R7", "indices cleared");
    p_clr();

    // R8: no automatic restart
    autor = 0; tmode = 1;
    p_trig(); ticks(1);
    lp_wait = 1; ticks(5);
    lp_wait = 0; ticks(1);
    chk(f_rsta | f_trig | f_seqa | f_ldok, 0, "R8", "exit sets nothing");
    ticks(2);
    chk(conv_busy, 0, "R8", "no conversion on exit");
    p_clr();

    // R11: software abort before wait
    p_trig(); ticks(1);
    p_abort();
    chk(idle, 0, "R11", "not idle with abort pending");
    ticks(4);
    chk(abort_done, 1, "R4", "software abort completes");
    chk(idle, 1, "R11", "idle after software abort");
    lp_wait = 1; ticks(3); lp_wait = 0; ticks(3);
    p_clr();

    // R9: buffer select kept across a wait mid-list
    p_ldok(); p_trig(); ticks(5);
    b0 = buf_sel;
    p_trig(); ticks(0);
    lp_wait = 1; ticks(6);
    chk(buf_sel, b0, "R9", "buffer kept across wait");
    chk(f_ldok, 0, "R5", "swap request cleared in wait");
    lp_wait = 0; ticks(2);
    p_clr();

    // Wait request in the very cycle a conversion completes
    autor = 1; store = 1;
    p_trig(); ticks(3);
    lp_wait = 1; ticks(4);
    chk(cmd_idx, 0, "R2", "abort after coincident completion");
    chk(abort_done, 1, "R4", "abort_done after coincident completion");
    lp_wait = 0; ticks(8);

    finish_run();
  end
endmodule